// File: doc/BRIEF.md
# Oversampled Serial Receive Data Recovery

This block recovers bytes from an asynchronous serial line. A sampling tick that runs at sixteen times the bit rate is supplied from outside. Each bit period is split into sixteen slots. The block hunts for a start bit and checks it with three early samples. It decides each data bit and the stop bit by a two-of-three vote.

Every frame ends with the byte and two quality flags. One flag reports disagreement among the samples. The other reports a bad stop bit. A ready flag stays set until the consumer pulses an acknowledge.

The line is resynchronized to the system clock before it is sampled. The bit timing is re-anchored at the start edge of each frame. It is also re-anchored at any falling edge found between a data bit that voted 1 and a following data bit that votes 0. This lets the receiver follow a sender whose bit periods run slightly long.

Top module: `uart_rx_recover`

## Requirements
- R1: After reset, and after every frame that ends or is rejected, a start is only recognised once the three samples (ticks) just before the low sample were all high.
- R2: A low sample that follows three high samples opens a frame. That tick is slot 1, and each later tick advances the slot by one, from 16 back to 1.
- R3: The start bit is checked with the samples at slots 3, 5 and 7. If none of them is high, the start is accepted with no noise. If exactly one is high, the start is accepted and the noise flag is set for that frame.
- R4: If two or three of the slot 3/5/7 samples are high, the start is dropped. The search then begins again and needs three new high samples.
- R5: There are eight data bits, received least significant bit first. Each bit is the majority of its samples at slots 8, 9 and 10. A single disagreeing sample does not change the byte presented on rx_byte_o.
- R6: noise_o is set for a frame if any data bit or the stop bit has samples at slots 8, 9 and 10 that are not all equal. A later frame with no disagreement and a clean start clears noise_o.
- R7: The stop bit is voted at slots 8 to 10. frame_err_o is 1 when the vote is 0 and 0 when the vote is 1. The byte is still delivered in both cases.
- R8: byte_ready_o rises one clock after the stop-bit vote. A one-clock read_ack_i pulse clears it. A new byte that arrives while it is set replaces rx_byte_o.
- R9: Some data bits vote 1 and are followed by a bit that votes 0. For these, the first low sample seen at slot e (1 to 7) of the later bit becomes slot 1 when that bit is voted. The slot count is reloaded to 11-e, so a bit period stretched by up to 6 ticks is followed correctly.
- R10: After reset, rx_byte_o is 0 and byte_ready_o, noise_o and frame_err_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_tick_i | input | 1 | One-clock enable at 16x the bit rate |
| serial_i | input | 1 | Asynchronous serial line, idle high |
| read_ack_i | input | 1 | Pulse that clears byte_ready_o |
| rx_byte_o | output | 8 | Last received byte |
| byte_ready_o | output | 1 | A byte is waiting to be read |
| noise_o | output | 1 | Last frame had disagreeing samples or a noisy start |
| frame_err_o | output | 1 | Last frame's stop bit voted 0 |

## Verification
Most internal faults appear at the ports within the frame that contains them.

- A slot counter that is off by one, or a vote taken at the wrong slot, still decodes clean frames. It only shows once a sample at slot 9 is corrupted, or once a bit period is stretched. The stretched-bit frames are built so that a missing re-anchor shifts the later sampling point back into the previous bit, which changes the byte.
- A wrong start-check decision appears on the flags and the ready bit of that same frame. A start history left set after a frame ends shows as a frame accepted with too few idle samples after reset.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;

  // two-of-three majority
  function automatic logic maj3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction

  // samples not unanimous
  function automatic logic split3(input logic [2:0] s);
    return (s != 3'b000) && (s != 3'b111);
  endfunction

  // start check passes with at most one high sample
  function automatic logic start_pass(input logic [2:0] s);
    return !maj3(s);
  endfunction

  // start check passes but exactly one sample disagreed
  function automatic logic start_noisy(input logic [2:0] s);
    return (s != 3'b000) && !maj3(s);
  endfunction

  // slot value for the voting tick so that the edge tick counts as slot 1
  function automatic int unsigned realign(input int unsigned vote_slot,
                                          input int unsigned edge_slot);
    return vote_slot - edge_slot + 1;
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/rx_slot_timer.sv
module rx_slot_timer #(
  parameter int OVS = 16,
  parameter int SW  = $clog2(OVS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          start_i,
  input  logic          run_i,
  input  logic          reload_i,
  input  logic [SW-1:0] reload_val_i,
  output logic [SW-1:0] cur_o,
  output logic [SW-1:0] slot_o
);
  logic [SW-1:0] slot_q;

  always_comb begin
    if (start_i)                 cur_o = SW'(1);
    else if (slot_q >= SW'(OVS)) cur_o = SW'(1);
    else                         cur_o = slot_q + SW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) slot_q <= '0;
    else if (tick_i) begin
      if (start_i)    slot_q <= SW'(1);
      else if (run_i) slot_q <= reload_i ? reload_val_i : cur_o;
      else            slot_q <= '0;
    end
  end

  assign slot_o = slot_q;

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q <= SW'(OVS)); // R2
  AST_START_SLOT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && start_i |=> slot_q == SW'(1)); // R2
endmodule

// File: rtl/rx_vote_unit.sv
module rx_vote_unit #(
  parameter int OVS      = 16,
  parameter int SW       = $clog2(OVS + 1),
  parameter int START_A  = 3,
  parameter int START_B  = 5,
  parameter int START_C  = 7,
  parameter int VOTE_MID = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic [SW-1:0] cur_i,
  input  logic          line_i,
  input  logic          active_i,
  input  logic          start_mode_i,
  output logic          start_eval_o,
  output logic [2:0]    start_pat_o,
  output logic          vote_o,
  output logic [2:0]    vote_pat_o,
  output logic          voted_o
);
  logic          smp_a_q, smp_b_q, voted_q;
  logic [SW-1:0] slot_a, slot_b, slot_c;

  always_comb begin
    slot_a = start_mode_i ? SW'(START_A) : SW'(VOTE_MID - 1);
    slot_b = start_mode_i ? SW'(START_B) : SW'(VOTE_MID);
    slot_c = start_mode_i ? SW'(START_C) : SW'(VOTE_MID + 1);
  end

  assign start_eval_o = tick_i && active_i && start_mode_i && (cur_i == slot_c);
  assign vote_o       = tick_i && active_i && !start_mode_i && !voted_q && (cur_i == slot_c);
  assign start_pat_o  = {smp_a_q, smp_b_q, line_i};
  assign vote_pat_o   = {smp_a_q, smp_b_q, line_i};
  assign voted_o      = voted_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_a_q <= 1'b0;
      smp_b_q <= 1'b0;
      voted_q <= 1'b0;
    end else if (!active_i) begin
      voted_q <= 1'b0;
    end else if (tick_i) begin
      if (!voted_q && cur_i == slot_a) smp_a_q <= line_i;
      if (!voted_q && cur_i == slot_b) smp_b_q <= line_i;
      if (vote_o)                      voted_q <= 1'b1;
      else if (cur_i == SW'(OVS))      voted_q <= 1'b0;
    end
  end

  AST_VOTE_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    vote_o |=> voted_q); // R5
endmodule

// File: rtl/uart_rx_recover.sv
module uart_rx_recover
  import uart_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2,
  parameter int HIST_LEN    = 3,
  parameter int START_A     = 3,
  parameter int START_B     = 5,
  parameter int START_C     = 7,
  parameter int VOTE_MID    = 9,
  parameter int EDGE_LAST   = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_tick_i,
  input  logic                 serial_i,
  input  logic                 read_ack_i,
  output logic [DATA_BITS-1:0] rx_byte_o,
  output logic                 byte_ready_o,
  output logic                 noise_o,
  output logic                 frame_err_o
);
  localparam int SW = $clog2(OVS + 1);
  localparam int IW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [HIST_LEN-1:0] HIST_IDLE = '1;

  rx_state_e            state_q;
  logic [HIST_LEN-1:0]  hist_q;
  logic [IW-1:0]        bit_idx_q;
  logic [DATA_BITS-1:0] shreg_q;
  logic                 prev_bit_q, noise_acc_q, edge_seen_q;
  logic [SW-1:0]        edge_slot_q;

  logic                 line;
  logic [SW-1:0]        cur_slot, slot_now, reload_val;
  logic                 start_eval, vote, voted;
  logic [2:0]           start_pat, vote_pat;
  logic                 vote_maj, vote_split;
  logic                 start_det, edge_cap, resync, byte_done, bit_end;

  rx_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .d_i(serial_i), .q_o(line)
  );

  rx_slot_timer #(.OVS(OVS), .SW(SW)) i_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(sample_tick_i),
    .start_i(start_det), .run_i(state_q != ST_HUNT),
    .reload_i(resync), .reload_val_i(reload_val),
    .cur_o(cur_slot), .slot_o(slot_now)
  );

  rx_vote_unit #(.OVS(OVS), .SW(SW), .START_A(START_A), .START_B(START_B),
                 .START_C(START_C), .VOTE_MID(VOTE_MID)) i_vote (
    .clk(clk), .rst_n(rst_n), .tick_i(sample_tick_i), .cur_i(cur_slot),
    .line_i(line), .active_i(state_q != ST_HUNT),
    .start_mode_i(state_q == ST_START),
    .start_eval_o(start_eval), .start_pat_o(start_pat),
    .vote_o(vote), .vote_pat_o(vote_pat), .voted_o(voted)
  );

  // named internal events
  assign vote_maj   = maj3(vote_pat);
  assign vote_split = split3(vote_pat);
  assign start_det  = sample_tick_i && (state_q == ST_HUNT) && !line && (hist_q == HIST_IDLE);
  assign edge_cap   = sample_tick_i && (state_q == ST_DATA) && !voted && !edge_seen_q &&
                      prev_bit_q && !line && (cur_slot <= SW'(EDGE_LAST));
  assign resync     = vote && (state_q == ST_DATA) && prev_bit_q && !vote_maj && edge_seen_q;
  assign reload_val = SW'(realign(VOTE_MID + 1, 32'(edge_slot_q)));
  assign byte_done  = vote && (state_q == ST_STOP);
  assign bit_end    = sample_tick_i && (cur_slot == SW'(OVS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_HUNT;
      hist_q       <= '0;
      bit_idx_q    <= '0;
      shreg_q      <= '0;
      prev_bit_q   <= 1'b0;
      noise_acc_q  <= 1'b0;
      edge_seen_q  <= 1'b0;
      edge_slot_q  <= '0;
      rx_byte_o    <= '0;
      byte_ready_o <= 1'b0;
      noise_o      <= 1'b0;
      frame_err_o  <= 1'b0;
    end else begin
      if (byte_done)       byte_ready_o <= 1'b1;
      else if (read_ack_i) byte_ready_o <= 1'b0;

      unique case (state_q)
        ST_HUNT: begin
          if (sample_tick_i) hist_q <= {hist_q[HIST_LEN-2:0], line};
          if (start_det) begin
            state_q     <= ST_START;
            noise_acc_q <= 1'b0;
          end
        end
        ST_START: begin
          if (start_eval) begin
            if (!start_pass(start_pat)) begin
              state_q <= ST_HUNT;
              hist_q  <= '0;
            end else begin
              noise_acc_q <= start_noisy(start_pat);
            end
          end else if (bit_end) begin
            state_q     <= ST_DATA;
            bit_idx_q   <= '0;
            prev_bit_q  <= 1'b0;
            edge_seen_q <= 1'b0;
          end
        end
        ST_DATA: begin
          if (edge_cap) begin
            edge_seen_q <= 1'b1;
            edge_slot_q <= cur_slot;
          end
          if (vote) begin
            shreg_q     <= {vote_maj, shreg_q[DATA_BITS-1:1]};
            noise_acc_q <= noise_acc_q | vote_split;
            prev_bit_q  <= vote_maj;
          end
          if (bit_end) begin
            edge_seen_q <= 1'b0;
            if (bit_idx_q == IW'(DATA_BITS - 1)) state_q <= ST_STOP;
            else bit_idx_q <= bit_idx_q + IW'(1);
          end
        end
        ST_STOP: begin
          if (vote) begin
            state_q     <= ST_HUNT;
            hist_q      <= '0;
            rx_byte_o   <= shreg_q;
            frame_err_o <= !vote_maj;
            noise_o     <= noise_acc_q | vote_split;
          end
        end
        default: state_q <= ST_HUNT;
      endcase
    end
  end

  AST_REJECT_TO_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
    start_eval && maj3(start_pat) |=> state_q == ST_HUNT); // R4
  AST_READY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> byte_ready_o); // R8
  AST_READY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    read_ack_i && !byte_done |=> !byte_ready_o); // R8
  AST_FERR_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> frame_err_o == !$past(vote_maj)); // R7
  AST_RESYNC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> slot_now == $past(reload_val)); // R9
  AST_HUNT_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> state_q == ST_HUNT && hist_q == '0); // R1
endmodule

// File: tb/test_uart_rx_recover.sv
`timescale 1ns/1ps
module test_uart_rx_recover;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rx = 1'b1;
  logic       ack = 1'b0;
  logic [7:0] rx_byte;
  logic       ready, noise, ferr;
  int         n_checks = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  uart_rx_recover i_uart_rx_recover (
    .clk(clk), .rst_n(rst_n), .sample_tick_i(tick), .serial_i(rx),
    .read_ack_i(ack), .rx_byte_o(rx_byte), .byte_ready_o(ready),
    .noise_o(noise), .frame_err_o(ferr)
  );

  // fields: data[17:10] stop[9] start_pattern(s3,s5,s7)[8:6] glitch_bit[5:2] (15 = none) ferr[1] noise[0]
  localparam logic [17:0] VEC [8] = '{
    {8'h55, 1'b1, 3'b000, 4'hF, 1'b0, 1'b0},
    {8'hA3, 1'b1, 3'b001, 4'hF, 1'b0, 1'b1},
    {8'h0F, 1'b1, 3'b010, 4'hF, 1'b0, 1'b1},
    {8'hF0, 1'b1, 3'b100, 4'hF, 1'b0, 1'b1},
    {8'h3C, 1'b0, 3'b000, 4'hF, 1'b1, 1'b0},
    {8'h81, 1'b1, 3'b000, 4'h3, 1'b0, 1'b1},
    {8'h00, 1'b1, 3'b000, 4'hF, 1'b0, 1'b0},
    {8'hFF, 1'b1, 3'b000, 4'h7, 1'b0, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic smp(input logic v);
    @(negedge clk) rx = v;
    repeat (3) @(negedge clk);
    tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] d, input logic stopv, input logic [2:0] spat,
                            input int glitch, input logic [7:0] stretch, input int idle);
    repeat (idle) smp(1'b1);
    for (int k = 1; k <= 16; k++)
      smp(k == 3 ? spat[2] : k == 5 ? spat[1] : k == 7 ? spat[0] : 1'b0);
    for (int b = 0; b < 8; b++)
      for (int k = 1; k <= 16 + (stretch[b] ? 6 : 0); k++)
        smp((glitch == b && k == 9) ? ~d[b] : d[b]);
    for (int k = 1; k <= 16; k++) smp(stopv);
  endtask

  task automatic ack_pulse();
    @(negedge clk) ack = 1'b1;
    @(negedge clk) ack = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check("R10 byte", rx_byte, 0);
    check("R10 ready", ready, 0);
    check("R10 noise", noise, 0);
    check("R10 ferr", ferr, 0);

    // R1: only two highs after reset, start must be ignored
    send_frame(8'h00, 1'b1, 3'b000, -1, 8'h00, 2);
    repeat (20) smp(1'b1);
    check("R1 ready", ready, 0);

    // table walk: R5 data, R7 ferr, R3 / R6 noise, R8 ready
    for (int i = 0; i < 8; i++) begin
      logic [17:0] v;
      v = VEC[i];
      send_frame(v[17:10], v[9], v[8:6], (v[5:2] == 4'hF) ? -1 : int'(v[5:2]), 8'h00, 20);
      check("R5 byte", rx_byte, v[17:10]);
      check("R7 ferr", ferr, v[1]);
      check((v[8:6] != 0) ? "R3 noise" : "R6 noise", noise, v[0]);
      check("R8 ready set", ready, 1);
      ack_pulse();
      check("R8 ready clear", ready, 0);
    end

    // R4: rejected start patterns
    for (int p = 0; p < 4; p++) begin
      logic [2:0] pat;
      pat = (p == 0) ? 3'b011 : (p == 1) ? 3'b101 : (p == 2) ? 3'b110 : 3'b111;
      repeat (5) smp(1'b1);
      for (int k = 1; k <= 16; k++)
        smp(k == 3 ? pat[2] : k == 5 ? pat[1] : k == 7 ? pat[0] : 1'b0);
      repeat (20) smp(1'b1);
      check("R4 reject", ready, 0);
    end
    // R4: search restarts after three new highs
    for (int k = 1; k <= 16; k++) smp(k == 5 || k == 7);
    send_frame(8'h5A, 1'b1, 3'b000, -1, 8'h00, 3);
    check("R4 recover byte", rx_byte, 8'h5A);
    check("R4 recover ready", ready, 1);
    ack_pulse();

    // R8: overwrite while ready
    send_frame(8'h11, 1'b1, 3'b000, -1, 8'h00, 20);
    send_frame(8'h22, 1'b1, 3'b000, -1, 8'h00, 20);
    check("R8 overwrite byte", rx_byte, 8'h22);
    check("R8 overwrite ready", ready, 1);
    ack_pulse();
    check("R8 cleared", ready, 0);

    // R9: bits 1 and 5 stretched by 6 ticks, falling edge follows each
    send_frame(8'hA2, 1'b1, 3'b000, -1, 8'b0010_0010, 20);
    check("R9 byte", rx_byte, 8'hA2);
    check("R9 noise", noise, 0);
    check("R9 ferr", ferr, 0);

    repeat (5) smp(1'b1);
    finish_run();
  end
endmodule